// File: doc/BRIEF.md
# Sequenced-Read I2C Monitor ADC Target

This block is the I2C target side of a multi-channel supply monitor. It holds eleven channel sample inputs (six supply rails, the core supply, the 12 V input, an on-die temperature sensor and two auxiliary analog inputs, indexed 0 to 10) and serves them through a two-phase read. The host first writes an offset byte naming a channel, then issues a repeated start with a read request. The target refuses that read with a NACK on purpose, and the refusal is what launches a conversion of the chosen channel. Once the conversion time has passed, the host performs a plain two-byte read and receives the result word, which carries the channel index next to the 10-bit sample.

The bus lines are sampled through synchronisers on the system clock. The target only ever pulls SDA low; the open-drain wire is resolved outside. The conversion time is 70 µs or 185 µs depending on a variant parameter and is counted in system clocks, with a busy flag raised while it runs. The analog conversion itself is outside the block: the sample of the chosen channel is taken from the sample bus when the conversion time ends.

Top module: `i2cMonTarget`

## Requirements
- R1: After reset, sdaPullLow and convBusy are 0, and a data read issued before any conversion returns the word 0x0000.
- R2: A transaction whose 7-bit address differs from TGT_ADDR is never acknowledged; the target leaves SDA released for the whole transaction, including any further bytes.
- R3: A write to TGT_ADDR is acknowledged; the next byte is a channel offset whose bits 6..3 give the channel index, acknowledged when the index is at most 10 and NACKed otherwise, in which case nothing is armed and a following read is an ordinary data read.
- R4: A repeated-start read to TGT_ADDR that follows an accepted offset in the same transaction is answered with NACK, and that NACK starts a conversion, raising convBusy.
- R5: convBusy stays high for exactly (SLOW_PART ? SLOW_US : FAST_US) × CLKS_PER_US clock cycles per conversion.
- R6: A read to TGT_ADDR with no armed offset is acknowledged and returns a 16-bit word, high byte first, each byte MSB first; bit 15 and bit 10 are 0, bits 14..11 hold the converted channel index and bits 9..0 the sample. The target changes SDA only while SCL is low.
- R7: The sample returned is the value on the channel's sample lane (bus bits [10·ch+9 : 10·ch]) at the end of the conversion, not at its start.
- R8: A data read whose address is acknowledged while a conversion is still running returns the previously latched word unchanged.
- R9: Sample codes are passed through untouched, so a two's-complement temperature code above 511 (channel 8) reads back with its sign bit 9 set.
- R10: A STOP clears an armed offset: a write of a valid offset, a STOP, then a read returns the latched word with ACK and starts no conversion.
- R11: A master NACK after the high byte ends the read: the low byte is not driven, and SDA reads as all ones for the following eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the SCL wire |
| sdaIn | input | 1 | Sensed level of the SDA wire |
| sampleBus | input | NUM_CH*SAMPLE_W | Packed channel samples, channel ch on bits [SAMPLE_W*ch +: SAMPLE_W] |
| sdaPullLow | output | 1 | 1 pulls the SDA wire low, 0 releases it |
| convBusy | output | 1 | High while a conversion is counting |

## Verification
The bound checker watches on every cycle that SDA only moves while SCL is low, that a conversion start is always a NACK followed by busy, that busy never rises without a start, that every busy window is exactly the conversion length, and that accepted channel indexes stay in range. What the checker cannot see is the content of the exchange: which word comes back, whether the sample is taken at the end of the window, that a read during busy returns stale data, and that a STOP or a bad offset disarms the conversion; those are shown by the bench's transaction sequences comparing returned bytes and acknowledge bits against values worked out from the requirements.

// File: rtl/monTgtPkg.sv
`timescale 1ns/1ps
package monTgtPkg;
  localparam int WORD_W = 16;
  localparam int CH_W = 4;
  localparam int CH_LSB = 11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ACK,
    S_RX,
    S_TX,
    S_MACK
  } busState_t;

  // strobes from the bus control to the sample datapath
  typedef struct packed {
    logic            setChan;
    logic [CH_W-1:0] chan;
    logic            convStart;
    logic            loadTx;
    logic            shiftTx;
  } dpCmd_t;
endpackage

// File: rtl/lineSync.sv
`timescale 1ns/1ps
module lineSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic levelPrev
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe      <= {STAGES{RESET_VAL}};
      levelPrev <= RESET_VAL;
    end else begin
      pipe      <= {pipe[STAGES-2:0], din};
      levelPrev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
endmodule

// File: rtl/busCtrl.sv
`timescale 1ns/1ps
module busCtrl
  import monTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h2C,
  parameter int         NUM_CH   = 11
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclLvl,
  input  logic   sclPrev,
  input  logic   sdaLvl,
  input  logic   sdaPrev,
  input  logic   txMsb,
  input  logic   txNext,
  output dpCmd_t cmd,
  output logic   sdaPullLow
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  busState_t state, nextAfterAck;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;
  logic armed, pullLow, secondByte, masterAck;

  logic startEv, stopEv, riseEv, fallEv, byteDone, addrHit, chanOk;

  assign startEv  = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv   = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign riseEv   = sclLvl & ~sclPrev;
  assign fallEv   = ~sclLvl & sclPrev;
  assign byteDone = fallEv && (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:1] == TGT_ADDR);
  assign chanOk   = (rxByte[6:3] <= LAST_CH);

  always_comb begin
    cmd      = '0;
    cmd.chan = rxByte[6:3];
    if (!startEv && !stopEv) begin
      case (state)
        S_ADDR: if (byteDone && addrHit && rxByte[0]) begin
          if (armed) cmd.convStart = 1'b1;
          else       cmd.loadTx    = 1'b1;
        end
        S_RX:   if (byteDone && chanOk) cmd.setChan = 1'b1;
        S_TX:   if (fallEv && (bitCnt != 4'd8)) cmd.shiftTx = 1'b1;
        S_MACK: if (fallEv && masterAck && !secondByte) cmd.shiftTx = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      nextAfterAck <= S_RX;
      bitCnt       <= '0;
      rxByte       <= '0;
      armed        <= 1'b0;
      pullLow      <= 1'b0;
      secondByte   <= 1'b0;
      masterAck    <= 1'b0;
    end else if (startEv) begin
      state   <= S_ADDR;
      bitCnt  <= '0;
      pullLow <= 1'b0;
    end else if (stopEv) begin
      state   <= S_IDLE;
      pullLow <= 1'b0;
      armed   <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_RX: begin
          if (riseEv && (bitCnt != 4'd8)) begin
            rxByte <= {rxByte[6:0], sdaLvl};
            bitCnt <= bitCnt + 4'd1;
          end
          if (byteDone) begin
            bitCnt <= '0;
            if (state == S_ADDR) begin
              if (!addrHit) begin
                state <= S_IDLE;
              end else if (!rxByte[0]) begin
                pullLow      <= 1'b1;
                state        <= S_ACK;
                nextAfterAck <= S_RX;
              end else if (armed) begin
                armed <= 1'b0;
                state <= S_IDLE;
              end else begin
                pullLow      <= 1'b1;
                state        <= S_ACK;
                nextAfterAck <= S_TX;
                secondByte   <= 1'b0;
              end
            end else begin
              if (chanOk) begin
                pullLow      <= 1'b1;
                armed        <= 1'b1;
                state        <= S_ACK;
                nextAfterAck <= S_RX;
              end else begin
                armed <= 1'b0;
                state <= S_IDLE;
              end
            end
          end
        end
        S_ACK: if (fallEv) begin
          bitCnt <= '0;
          if (nextAfterAck == S_TX) begin
            pullLow <= ~txMsb;
            state   <= S_TX;
          end else begin
            pullLow <= 1'b0;
            state   <= S_RX;
          end
        end
        S_TX: begin
          if (riseEv) bitCnt <= bitCnt + 4'd1;
          if (fallEv) begin
            if (bitCnt == 4'd8) begin
              pullLow <= 1'b0;
              state   <= S_MACK;
            end else begin
              pullLow <= ~txNext;
            end
          end
        end
        S_MACK: begin
          if (riseEv) masterAck <= ~sdaLvl;
          if (fallEv) begin
            bitCnt <= '0;
            if (masterAck && !secondByte) begin
              secondByte <= 1'b1;
              pullLow    <= ~txNext;
              state      <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = pullLow;
endmodule

// File: rtl/sampleDp.sv
`timescale 1ns/1ps
module sampleDp
  import monTgtPkg::*;
#(
  parameter int NUM_CH    = 11,
  parameter int SAMPLE_W  = 10,
  parameter int CONV_CLKS = 3500
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCmd_t                     cmd,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  output logic                       convBusy,
  output logic                       txMsb,
  output logic                       txNext
);
  localparam int CNT_W = $clog2(CONV_CLKS + 1);

  logic [SAMPLE_W-1:0] chanSample [NUM_CH];
  logic [CH_W-1:0]     selChan, convChan;
  logic [CNT_W-1:0]    remain;
  logic [WORD_W-1:0]   resultWord, txShift, nextWord;

  for (genvar g = 0; g < NUM_CH; g++) begin : gLane
    assign chanSample[g] = sampleBus[g*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    nextWord                       = '0;
    nextWord[CH_LSB +: CH_W]       = convChan;
    nextWord[SAMPLE_W-1:0]         = chanSample[convChan];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selChan    <= '0;
      convChan   <= '0;
      remain     <= '0;
      convBusy   <= 1'b0;
      resultWord <= '0;
      txShift    <= '0;
    end else begin
      if (cmd.setChan) selChan <= cmd.chan;

      if (cmd.convStart) begin
        convChan <= selChan;
        remain   <= CNT_W'(CONV_CLKS - 1);
        convBusy <= 1'b1;
      end else if (convBusy) begin
        if (remain == '0) begin
          convBusy   <= 1'b0;
          resultWord <= nextWord;
        end else begin
          remain <= remain - 1'b1;
        end
      end

      if (cmd.loadTx)       txShift <= resultWord;
      else if (cmd.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  assign txMsb  = txShift[WORD_W-1];
  assign txNext = txShift[WORD_W-2];
endmodule

// File: rtl/i2cMonTarget.sv
`timescale 1ns/1ps
module i2cMonTarget
  import monTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h2C,
  parameter int         NUM_CH      = 11,
  parameter int         SAMPLE_W    = 10,
  parameter int         CLKS_PER_US = 50,
  parameter bit         SLOW_PART   = 1'b0,
  parameter int         FAST_US     = 70,
  parameter int         SLOW_US     = 185,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  output logic                       sdaPullLow,
  output logic                       convBusy
);
  localparam int CONV_CLKS = (SLOW_PART ? SLOW_US : FAST_US) * CLKS_PER_US;

  logic [1:0] rawLines, lineLvl, linePrev;
  dpCmd_t dpCmd;
  logic txMsb, txNext;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    lineSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSync (
      .clk(clk), .rstN(rstN), .din(rawLines[g]),
      .level(lineLvl[g]), .levelPrev(linePrev[g])
    );
  end

  busCtrl #(.TGT_ADDR(TGT_ADDR), .NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sclLvl(lineLvl[0]), .sclPrev(linePrev[0]),
    .sdaLvl(lineLvl[1]), .sdaPrev(linePrev[1]),
    .txMsb(txMsb), .txNext(txNext),
    .cmd(dpCmd), .sdaPullLow(sdaPullLow)
  );

  sampleDp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CONV_CLKS(CONV_CLKS)) uDp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .sampleBus(sampleBus),
    .convBusy(convBusy), .txMsb(txMsb), .txNext(txNext)
  );
endmodule

// File: rtl/monTgtChecker.sv
`timescale 1ns/1ps
module monTgtChecker
  import monTgtPkg::*;
#(
  parameter int NUM_CH    = 11,
  parameter int CONV_CLKS = 3500
) (
  input logic   clk,
  input logic   rstN,
  input logic   sclIn,
  input logic   sdaPullLow,
  input logic   convBusy,
  input dpCmd_t cmd
);
  localparam int CNT_W = $clog2(CONV_CLKS + 1);
  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runLen <= '0;
    else if (cmd.convStart) runLen <= '0;
    else if (convBusy)      runLen <= runLen + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!convBusy && !sdaPullLow));

  p_sda_moves_low_scl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

  p_start_nacks_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.convStart |=> (!sdaPullLow && convBusy));

  p_busy_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convBusy) |-> $past(cmd.convStart));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convBusy) |-> (runLen == CNT_W'(CONV_CLKS)));

  p_chan_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setChan |-> (cmd.chan < CH_W'(NUM_CH)));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setChan, cmd.convStart, cmd.loadTx, cmd.shiftTx}));
endmodule

bind i2cMonTarget monTgtChecker #(.NUM_CH(NUM_CH), .CONV_CLKS(CONV_CLKS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .convBusy(convBusy), .cmd(dpCmd)
);

// File: tb/i2cMonTarget_test.sv
`timescale 1ns/1ps
module i2cMonTarget_test;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int CPU  = 8;
  localparam int CONV = 70 * CPU;

  // {channel[3:0], sample[9:0], expected word[15:0]}
  localparam logic [29:0] VEC [7] = '{
    {4'd0,  10'h155, 16'h0155},
    {4'd3,  10'h2AA, 16'h1AAA},
    {4'd7,  10'h3FF, 16'h3BFF},
    {4'd10, 10'h001, 16'h5001},
    {4'd8,  10'h3F0, 16'h43F0},
    {4'd5,  10'h200, 16'h2A00},
    {4'd1,  10'h000, 16'h0800}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic [109:0] samples = '0;
  logic sdaPullLow, convBusy;
  wire  sdaLine = ~(mLow | sdaPullLow);

  i2cMonTarget #(.TGT_ADDR(ADDR), .CLKS_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sampleBus(samples), .sdaPullLow(sdaPullLow), .convBusy(convBusy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int busyRun = 0;
  int lastRun = 0;
  bit anyPull = 1'b0;

  always @(negedge clk) begin
    if (convBusy) busyRun++;
    else if (busyRun != 0) begin
      lastRun = busyRun;
      busyRun = 0;
    end
    if (sdaPullLow) anyPull = 1'b1;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mStart();
    mLow = 1'b0; #100;
    scl = 1'b1;  #100;
    mLow = 1'b1; #100;
    scl = 1'b0;  #100;
  endtask

  task automatic mStop();
    mLow = 1'b1; #100;
    scl = 1'b1;  #100;
    mLow = 1'b0; #100;
  endtask

  task automatic mBit(input bit b, output bit r);
    mLow = ~b;   #100;
    scl = 1'b1;  #100;
    r = sdaLine; #100;
    scl = 1'b0;  #100;
  endtask

  task automatic mWrite(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) mBit(v[i], r);
    mBit(1'b1, r);
    ack = ~r;
  endtask

  task automatic mRead(input bit giveAck, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, r);
      v[i] = r;
    end
    mBit(~giveAck, r);
  endtask

  task automatic readWord(output bit ack, output logic [15:0] w);
    logic [7:0] hi, lo;
    mStart();
    mWrite({ADDR, 1'b1}, ack);
    mRead(1'b1, hi);
    mRead(1'b0, lo);
    mStop();
    w = {hi, lo};
  endtask

  // write offset, repeated-start read (NACKed), stop
  task automatic arm(input logic [3:0] ch, output bit ackA, output bit ackO, output bit ackR);
    mStart();
    mWrite({ADDR, 1'b0}, ackA);
    mWrite({1'b0, ch, 3'b000}, ackO);
    mStart();
    mWrite({ADDR, 1'b1}, ackR);
    mStop();
  endtask

  task automatic waitIdle();
    while (convBusy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ackA, ackO, ackR;
    logic [15:0] word, prevWord;
    logic [7:0] hi, lo;

    repeat (5) @(negedge clk);
    check("R1", "busy in reset", 32'(convBusy), 32'd0);
    check("R1", "sda drive in reset", 32'(sdaPullLow), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    readWord(ackR, word);
    check("R1", "first read ack", 32'(ackR), 32'd1);
    check("R1", "first read word", 32'(word), 32'h0000);
    prevWord = word;

    for (int i = 0; i < 7; i++) begin
      logic [3:0]  ch;
      logic [9:0]  smp;
      logic [15:0] exp;
      {ch, smp, exp} = VEC[i];
      samples[ch*10 +: 10] = smp;
      arm(ch, ackA, ackO, ackR);
      check("R3", "write address ack", 32'(ackA), 32'd1);
      check("R3", "valid offset ack", 32'(ackO), 32'd1);
      check("R4", "arming read is NACKed", 32'(ackR), 32'd0);
      check("R4", "busy after NACK", 32'(convBusy), 32'd1);
      waitIdle();
      check("R5", "busy length", 32'(lastRun), 32'(CONV));
      readWord(ackR, word);
      check("R6", "data read ack", 32'(ackR), 32'd1);
      if (ch == 4'd8) check("R9", "temperature word", 32'(word), 32'(exp));
      else            check("R6", "result word", 32'(word), 32'(exp));
      prevWord = word;
    end

    // R2: foreign address is ignored
    anyPull = 1'b0;
    mStart();
    mWrite({7'h2D, 1'b0}, ackA);
    mWrite(8'h08, ackO);
    mStop();
    check("R2", "foreign address ack", 32'(ackA), 32'd0);
    check("R2", "foreign data ack", 32'(ackO), 32'd0);
    check("R2", "sda never pulled", 32'(anyPull), 32'd0);

    // R3: out-of-range offset is NACKed and arms nothing
    mStart();
    mWrite({ADDR, 1'b0}, ackA);
    mWrite(8'h58, ackO);
    check("R3", "offset index 11 NACKed", 32'(ackO), 32'd0);
    mStart();
    mWrite({ADDR, 1'b1}, ackR);
    mRead(1'b1, hi);
    mRead(1'b0, lo);
    mStop();
    check("R3", "read after bad offset ack", 32'(ackR), 32'd1);
    check("R3", "read after bad offset word", 32'({hi, lo}), 32'(prevWord));
    check("R3", "no conversion after bad offset", 32'(convBusy), 32'd0);

    // R8 and R7: read during busy, sample changes mid-conversion
    samples[2*10 +: 10] = 10'h0AB;
    arm(4'd2, ackA, ackO, ackR);
    samples[2*10 +: 10] = 10'h0CD;
    check("R8", "conversion running", 32'(convBusy), 32'd1);
    readWord(ackR, word);
    check("R8", "read during busy ack", 32'(ackR), 32'd1);
    check("R8", "read during busy returns old word", 32'(word), 32'(prevWord));
    waitIdle();
    readWord(ackR, word);
    check("R7", "sample taken at end", 32'(word), 32'h10CD);
    prevWord = word;

    // R10: STOP disarms
    mStart();
    mWrite({ADDR, 1'b0}, ackA);
    mWrite({1'b0, 4'd4, 3'b000}, ackO);
    mStop();
    samples[4*10 +: 10] = 10'h111;
    readWord(ackR, word);
    check("R10", "read after stop ack", 32'(ackR), 32'd1);
    check("R10", "read after stop word", 32'(word), 32'(prevWord));
    repeat (4) @(negedge clk);
    check("R10", "no conversion after stop", 32'(convBusy), 32'd0);

    // R11: master NACK after high byte
    mStart();
    mWrite({ADDR, 1'b1}, ackR);
    mRead(1'b0, hi);
    mRead(1'b0, lo);
    mStop();
    check("R11", "high byte", 32'(hi), 32'(prevWord[15:8]));
    check("R11", "low byte not driven", 32'(lo), 32'h00FF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule